// File: doc/BRIEF.md
# Accumulator Shift and Rotate Unit

This block keeps a 56-bit signed accumulator and moves its bits one place at a time. The accumulator is built from three fields. From the top down they are an 8-bit guard field (bits 55..48), a 24-bit upper word (bits 47..24) and a 24-bit lower word (bits 23..0). The two arithmetic operations shift all 56 bits. The two logical shifts and the two rotates touch only the upper word. Every operation loads a single carry flag with the bit that leaves the field. The rotates pass through this flag, so the upper word and the flag together form a 25-bit ring.

A command gives an operation code and a repeat count. A small sequencer then applies the chosen one-bit step once per clock for that many cycles. It raises `busy` for the whole run and pulses `done` once after the last step. The accumulator can also be written directly through a load port.

A 24-bit read port shows a view of the accumulator with no delay. The view is either unscaled, scaled down by one bit or scaled up by one bit, depending on a 2-bit mode input. Reading the port does not change the accumulator and adds no cycles.

Top module: `acc_shift_unit`

## Requirements
- R1: A synchronous reset clears the accumulator and the carry flag, and leaves `busy` and `done` low.
- R2: When `loadEn` is high and the unit is idle, `accOut` equals `loadValue` after the next clock. Carry is unchanged. If a load and a command arrive in the same idle cycle, the load wins and the command is dropped.
- R3: Operation code 0 (arithmetic left) shifts all 56 bits up by one per step. Bit 0 is filled with zero, and carry takes the old bit 55.
- R4: Operation code 1 (arithmetic right) shifts all 56 bits down by one per step. Bit 55 keeps its value, and carry takes the old bit 0.
- R5: Operation codes 2 (logical left) and 3 (logical right) shift bits 47..24 by one per step. The vacated bit is filled with zero, and carry takes the bit shifted out. Bits 55..48 and 23..0 do not change.
- R6: Operation codes 4 (rotate left) and 5 (rotate right) rotate bits 47..24 through carry. Left: bit 24 takes the old carry and carry takes the old bit 47. Right: bit 47 takes the old carry and carry takes the old bit 24. The other fields do not change.
- R7: A command with count n > 0, accepted in an idle cycle, makes `busy` high for exactly the n cycles after acceptance. One step is applied at the end of each of those cycles. `done` is high for the single cycle after the last step.
- R8: A command with count zero leaves the accumulator and carry unchanged and keeps `busy` low. `done` is high in the cycle after acceptance.
- R9: While `busy` is high, `cmdValid` and `loadEn` have no effect.
- R10: `busData` follows `scaleMode` with no delay. Mode 00 shows bits 47..24, mode 01 shows bits 48..25 (scale down), and mode 10 shows bits 46..23 (scale up). Mode 11 behaves as mode 00.
- R11: Operation codes 6 and 7 run the sequencer like any other code but leave the accumulator and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Write `loadValue` into the accumulator |
| loadValue | input | 56 | Value for a direct load |
| cmdValid | input | 1 | Start a shift or rotate command |
| cmdOp | input | 3 | Operation code (0 to 7, see R3 to R6 and R11) |
| cmdCount | input | 6 | Number of one-bit steps |
| scaleMode | input | 2 | Read-port scaling mode |
| accOut | output | 56 | Accumulator contents |
| carryOut | output | 1 | Carry flag |
| busData | output | 24 | Scaled 24-bit view of the accumulator |
| busy | output | 1 | Repeat loop running |
| done | output | 1 | One-cycle pulse after a command ends |

## Verification
The hardest cases to reach are the ones that depend on timing inside the repeat loop. A command or load must arrive while a run is still going, and the carry ring must be driven across many rotate steps. The stimulus starts a long arithmetic-right run and then pulses both the command and the load inputs in the middle of it. It also rotates by 25 positions, which must bring the upper word and carry back to where they started. A behavioural model is compared on every cycle, across fixed cases and a long sequence of random loads, operation codes, counts (including zero) and scale modes.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  typedef enum logic [2:0] {
    OP_ASL   = 3'd0,
    OP_ASR   = 3'd1,
    OP_LSL   = 3'd2,
    OP_LSR   = 3'd3,
    OP_ROL   = 3'd4,
    OP_ROR   = 3'd5,
    OP_NOP_A = 3'd6,
    OP_NOP_B = 3'd7
  } shiftOp_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic     loadStb;
    logic     stepStb;
    shiftOp_t op;
  } dpCtrl_t;

  localparam logic [1:0] SCALE_NONE = 2'b00;
  localparam logic [1:0] SCALE_DOWN = 2'b01;
  localparam logic [1:0] SCALE_UP   = 2'b10;

endpackage

// File: rtl/acc_shift_ctrl.sv
module acc_shift_ctrl
  import acc_shift_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [CNT_W-1:0] cmdCount,
  output dpCtrl_t          dpCtrl,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remaining;
  shiftOp_t         activeOp;
  logic             busyQ;
  logic             doneQ;
  logic             loadGo;
  logic             acceptCmd;

  // Loads and commands are only taken when idle; a load beats a command.
  assign loadGo    = loadEn && !busyQ;
  assign acceptCmd = cmdValid && !loadEn && !busyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ     <= 1'b0;
      doneQ     <= 1'b0;
      remaining <= '0;
      activeOp  <= OP_ASL;
    end else begin
      doneQ <= 1'b0;
      if (busyQ) begin
        remaining <= remaining - ONE;
        if (remaining == ONE) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end else if (acceptCmd) begin
        if (cmdCount == '0) begin
          doneQ <= 1'b1;
        end else begin
          busyQ     <= 1'b1;
          remaining <= cmdCount;
          activeOp  <= shiftOp_t'(cmdOp);
        end
      end
    end
  end

  assign dpCtrl.loadStb = loadGo;
  assign dpCtrl.stepStb = busyQ;
  assign dpCtrl.op      = activeOp;
  assign busy           = busyQ;
  assign done           = doneQ;

  // R7: the end of a run is always marked by done
  a_r7_fall_gives_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busyQ) |-> doneQ);

  // R7: a run with more than one step left keeps going
  a_r7_run_continues: assert property (@(posedge clk) disable iff (rst)
    (busyQ && remaining > ONE) |=> busyQ);

  // R8: a zero count finishes at once without a run
  a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !loadEn && !busyQ && cmdCount == '0) |=> (!busyQ && doneQ));

  // R9: a run keeps its operation whatever arrives at the inputs
  a_r9_op_held: assert property (@(posedge clk) disable iff (rst)
    (busyQ && remaining > ONE) |=> $stable(activeOp));

endmodule

// File: rtl/acc_shift_dp.sv
module acc_shift_dp
  import acc_shift_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dpCtrl_t                        dpCtrl,
  input  logic [EXT_W+2*WORD_W-1:0]      loadValue,
  input  logic [1:0]                     scaleMode,
  output logic [EXT_W+2*WORD_W-1:0]      acc,
  output logic                           carry,
  output logic [WORD_W-1:0]              busData
);

  localparam int ACC_W  = EXT_W + 2 * WORD_W;
  localparam int HI_LSB = WORD_W;
  localparam int HI_MSB = 2 * WORD_W - 1;

  logic [ACC_W-1:0]  nextAcc;
  logic              nextCarry;
  logic [WORD_W-1:0] hiWord;
  logic [WORD_W-1:0] newHi;
  logic              wordOp;

  assign hiWord = acc[HI_MSB:HI_LSB];
  assign wordOp = (dpCtrl.op == OP_LSL) || (dpCtrl.op == OP_LSR) ||
                  (dpCtrl.op == OP_ROL) || (dpCtrl.op == OP_ROR);

  always_comb begin
    nextAcc   = acc;
    nextCarry = carry;
    newHi     = hiWord;
    unique case (dpCtrl.op)
      OP_ASL: begin
        nextAcc   = {acc[ACC_W-2:0], 1'b0};
        nextCarry = acc[ACC_W-1];
      end
      OP_ASR: begin
        nextAcc   = {acc[ACC_W-1], acc[ACC_W-1:1]};
        nextCarry = acc[0];
      end
      OP_LSL: begin
        newHi     = {hiWord[WORD_W-2:0], 1'b0};
        nextCarry = hiWord[WORD_W-1];
      end
      OP_LSR: begin
        newHi     = {1'b0, hiWord[WORD_W-1:1]};
        nextCarry = hiWord[0];
      end
      OP_ROL: begin
        newHi     = {hiWord[WORD_W-2:0], carry};
        nextCarry = hiWord[WORD_W-1];
      end
      OP_ROR: begin
        newHi     = {carry, hiWord[WORD_W-1:1]};
        nextCarry = hiWord[0];
      end
      default: begin
        nextCarry = carry;
      end
    endcase
    if (wordOp) begin
      nextAcc[HI_MSB:HI_LSB] = newHi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      carry <= 1'b0;
    end else if (dpCtrl.loadStb) begin
      acc <= loadValue;
    end else if (dpCtrl.stepStb) begin
      acc   <= nextAcc;
      carry <= nextCarry;
    end
  end

  // Read-out scaler: one-bit window move, no register on the way.
  always_comb begin
    unique case (scaleMode)
      SCALE_DOWN: busData = acc[HI_MSB+1:HI_LSB+1];
      SCALE_UP:   busData = acc[HI_MSB-1:HI_LSB-1];
      default:    busData = hiWord;
    endcase
  end

  // R2: a load lands unchanged and carry is untouched
  a_r2_load_lands: assert property (@(posedge clk) disable iff (rst)
    dpCtrl.loadStb |=> (acc == $past(loadValue) && carry == $past(carry)));

  // R4: arithmetic right keeps the sign bit
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.stepStb && !dpCtrl.loadStb && dpCtrl.op == OP_ASR)
      |=> acc[ACC_W-1] == $past(acc[ACC_W-1]));

  // R5 / R6: word operations leave guard and lower fields alone
  a_r5_fields_kept: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.stepStb && !dpCtrl.loadStb && wordOp)
      |=> ($stable(acc[HI_LSB-1:0]) && $stable(acc[ACC_W-1:HI_MSB+1])));

  // R6: a rotate step neither creates nor loses ones in the carry ring
  a_r6_ring_conserved: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.stepStb && !dpCtrl.loadStb &&
     (dpCtrl.op == OP_ROL || dpCtrl.op == OP_ROR))
      |=> $countones({acc[HI_MSB:HI_LSB], carry}) ==
          $past($countones({acc[HI_MSB:HI_LSB], carry})));

endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      loadEn,
  input  logic [EXT_W+2*WORD_W-1:0] loadValue,
  input  logic                      cmdValid,
  input  logic [2:0]                cmdOp,
  input  logic [CNT_W-1:0]          cmdCount,
  input  logic [1:0]                scaleMode,
  output logic [EXT_W+2*WORD_W-1:0] accOut,
  output logic                      carryOut,
  output logic [WORD_W-1:0]         busData,
  output logic                      busy,
  output logic                      done
);

  dpCtrl_t dpCtrl;

  acc_shift_ctrl #(.CNT_W(CNT_W)) ctrlInst (
    .clk      (clk),
    .rst      (rst),
    .loadEn   (loadEn),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdCount (cmdCount),
    .dpCtrl   (dpCtrl),
    .busy     (busy),
    .done     (done)
  );

  acc_shift_dp #(.EXT_W(EXT_W), .WORD_W(WORD_W)) dpInst (
    .clk       (clk),
    .rst       (rst),
    .dpCtrl    (dpCtrl),
    .loadValue (loadValue),
    .scaleMode (scaleMode),
    .acc       (accOut),
    .carry     (carryOut),
    .busData   (busData)
  );

endmodule

// File: tb/acc_shift_unit_test.sv
`timescale 1ns/100ps
module acc_shift_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic [55:0] loadValue = '0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [5:0]  cmdCount = '0;
  logic [1:0]  scaleMode = '0;
  logic [55:0] accOut;
  logic        carryOut;
  logic [23:0] busData;
  logic        busy;
  logic        done;

  always #2.5 clk = ~clk;

  acc_shift_unit uut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadValue(loadValue),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdCount(cmdCount),
    .scaleMode(scaleMode), .accOut(accOut), .carryOut(carryOut),
    .busData(busData), .busy(busy), .done(done)
  );

  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 0;
  bit    started = 0;

  // Behavioural reference model
  logic [55:0] mAcc = '0;
  logic        mCarry = 1'b0;
  bit          mBusy = 0;
  bit          mDone = 0;
  int          mRem = 0;
  int          mOp = 0;
  string       mTag = "R1";

  task automatic chk(bit ok, string tag, logic [55:0] act, logic [55:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(int op);
    logic [23:0] h;
    logic        c;
    h = mAcc[47:24];
    c = mCarry;
    case (op)
      0: begin mCarry = mAcc[55]; mAcc = mAcc << 1; mTag = "R3"; end
      1: begin mCarry = mAcc[0]; mAcc = $signed(mAcc) >>> 1; mTag = "R4"; end
      2: begin mCarry = h[23]; mAcc[47:24] = h << 1; mTag = "R5"; end
      3: begin mCarry = h[0]; mAcc[47:24] = h >> 1; mTag = "R5"; end
      4: begin mCarry = h[23]; mAcc[47:24] = {h[22:0], c}; mTag = "R6"; end
      5: begin mCarry = h[0]; mAcc[47:24] = {c, h[23:1]}; mTag = "R6"; end
      default: mTag = "R11";
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mAcc = '0; mCarry = 0; mBusy = 0; mDone = 0; mRem = 0; mTag = "R1";
    end else begin
      bit nd;
      nd = 0;
      if (mBusy) begin
        modelStep(mOp);
        if (loadEn || cmdValid) mTag = "R9";
        mRem--;
        if (mRem == 0) begin mBusy = 0; nd = 1; end
      end else if (loadEn) begin
        mAcc = loadValue; mTag = "R2";
      end else if (cmdValid) begin
        if (cmdCount == 0) begin nd = 1; mTag = "R8"; end
        else begin mBusy = 1; mRem = cmdCount; mOp = cmdOp; end
      end
      mDone = nd;
    end
  end

  function automatic logic [23:0] expBus(logic [55:0] a, logic [1:0] m);
    case (m)
      2'b01:   return a[48:25];
      2'b10:   return a[46:23];
      default: return a[47:24];
    endcase
  endfunction

  // Compare every cycle, away from both edges
  always @(negedge clk) begin
    #1;
    if (started && !finished) begin
      chk(accOut == mAcc, mTag, accOut, mAcc);
      chk(carryOut == mCarry, mTag, 56'(carryOut), 56'(mCarry));
      chk(busy == mBusy, "R7 busy", 56'(busy), 56'(mBusy));
      chk(done == mDone, "R7 done", 56'(done), 56'(mDone));
      chk(busData == expBus(mAcc, scaleMode), "R10", 56'(busData),
          56'(expBus(mAcc, scaleMode)));
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doLoad(logic [55:0] v);
    @(negedge clk);
    loadEn = 1; loadValue = v;
    @(negedge clk);
    loadEn = 0;
  endtask

  task automatic doCmd(int op, int cnt);
    @(negedge clk);
    cmdValid = 1; cmdOp = 3'(op); cmdCount = 6'(cnt);
    @(negedge clk);
    cmdValid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R7 watchdog expired actual=running expected=idle");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    #1;
    // R1: reset state
    chk(accOut == 0 && carryOut == 0, "R1", accOut, 56'h0);
    chk(!busy && !done, "R1 ctrl", 56'({busy, done}), 56'h0);

    // R3: explicit value for an arithmetic left step
    doLoad(56'h80_000001_000001);
    doCmd(0, 1);
    #1;
    chk(accOut == 56'h00_000002_000002, "R3", accOut, 56'h00_000002_000002);
    chk(carryOut == 1'b1, "R3 carry", 56'(carryOut), 56'h1);

    // Every opcode with a few counts
    for (int op = 0; op < 8; op++) begin
      for (int c = 1; c < 5; c += 3) begin
        doLoad(56'hA5_C30F81_7E19B4 ^ 56'(op * 56'h1111_1111_1111));
        doCmd(op, c);
      end
    end

    // R6: 25 rotate steps return to start
    doLoad(56'h3C_9A5F01_123456);
    doCmd(4, 25);
    #1;
    chk(accOut == 56'h3C_9A5F01_123456, "R6 ring", accOut, 56'h3C_9A5F01_123456);
    doCmd(5, 25);

    // R8: zero count
    doCmd(1, 0);

    // R9: inputs pulsed during a long run
    doLoad(56'hF0_00FF00_ABCDEF);
    @(negedge clk);
    cmdValid = 1; cmdOp = 3'd1; cmdCount = 6'd20;
    @(negedge clk);
    cmdOp = 3'd0; cmdCount = 6'd1;
    repeat (3) @(negedge clk);
    cmdValid = 0; loadEn = 1; loadValue = 56'h12_345678_9ABCDE;
    repeat (2) @(negedge clk);
    loadEn = 0;
    waitIdle();

    // R10: all scale modes
    for (int m = 0; m < 4; m++) begin
      scaleMode = 2'(m);
      doLoad(56'h01_800001_800000);
      doLoad(56'hFE_7FFFFE_7FFFFF);
    end

    // Random mix
    for (int i = 0; i < 300; i++) begin
      scaleMode = 2'($urandom_range(0, 3));
      doLoad({$urandom(), $urandom()} >> 8);
      doCmd($urandom_range(0, 7), $urandom_range(0, 9));
    end

    waitIdle();
    summary();
  end

endmodule